// File: doc/BRIEF.md
# MSI Write-Back Snoop Controller

This block keeps a small direct-mapped cache coherent with its peers on a shared, totally ordered snooping bus. Every line holds a tag and one of three coherence states: Modified (this cache has the only valid copy and memory is stale), Shared (clean copy, memory owns the block) or Invalid. The processor side issues loads, stores and evictions. When a request cannot be served locally, the controller issues a bus transaction and waits for the grant. It issues a shared read, an exclusive read or a write-back.

The controller also watches every transaction that other caches put on the bus. It downgrades or invalidates its own copy as the protocol requires. When it holds the snooped line Modified, it raises a supply strobe naming the line and the requester, so the owner rather than memory answers. Memory answers whenever no strobe appears. The data path itself is outside the block; the strobe marks where a cache-to-cache transfer would start.

The bus is treated as atomic. The surrounding system does not present a foreign snoop to the index of a request that is waiting for its grant.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: A load whose line is Invalid or holds another tag issues a shared read (bus command code 1) for the request address and leaves the line Shared with the new tag. A load to a Shared or Modified line with a matching tag completes with no bus transaction.
- R2: A store whose line is Invalid, holds another tag, or is Shared with a matching tag issues an exclusive read (code 2) and leaves the line Modified. A store to a matching Modified line completes with no bus transaction.
- R3: A foreign snoop (snoop source differing from the MY_ID parameter) of code 1 or 2 that matches a Modified line raises supply_valid in the same cycle, with supply_index equal to the low IDX_W address bits and supply_dst equal to the snoop source. The line then becomes Shared after code 1 and Invalid after code 2.
- R4: A foreign exclusive read that matches a Shared line makes it Invalid. A foreign shared read leaves a Shared line unchanged. Neither raises supply_valid, and a snoop to an Invalid or tag-mismatched line raises nothing, so memory answers.
- R5: Evicting a matching Modified line issues a write-back (code 3) of its address and leaves it Invalid. Evicting a matching Shared line invalidates it silently. Evicting anything else changes nothing. Processor operation codes are load 0, store 1, evict 2.
- R6: A foreign write-back snoop (code 3) never changes any line or raises supply_valid. A snoop carrying this cache's own ID is ignored entirely.
- R7: A load or store miss that displaces a Modified line first issues a write-back of the old tag and index, then the fill read. Each transaction keeps bus_req, bus_cmd and bus_addr steady until the cycle bus_gnt is high. bus_cmd reads 0 when no request is pending.
- R8: cpu_resp_valid is a one-cycle pulse. It comes the cycle after acceptance for requests needing no bus transaction, and the cycle after the last grant otherwise. cpu_resp_hit is 1 exactly when no bus transaction was issued.
- R9: cpu_req_ready is high only when no request is in progress. It is low in a cycle where a foreign valid snoop targets the same index as the presented request.
- R10: After reset every line is Invalid, no bus request or response is pending, and cpu_req_ready is high. Addresses are split as tag in the high bits and index in the low IDX_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_op | input | 2 | Operation: 0 load, 1 store, 2 evict |
| cpu_req_addr | input | ADDR_W | Block address |
| cpu_req_ready | output | 1 | Request accepted when high with valid |
| cpu_resp_valid | output | 1 | Completion pulse |
| cpu_resp_hit | output | 1 | Completed without a bus transaction |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 0 none, 1 shared read, 2 exclusive read, 3 write-back |
| bus_addr | output | ADDR_W | Address of the bus transaction |
| bus_src | output | ID_W | Requester ID of this cache |
| bus_gnt | input | 1 | Grant; the transaction completes in a cycle where it is high |
| snoop_valid | input | 1 | Observed bus transaction present |
| snoop_cmd | input | 2 | Observed command, same encoding as bus_cmd |
| snoop_addr | input | ADDR_W | Observed address |
| snoop_src | input | ID_W | Requester ID of the observed transaction |
| supply_valid | output | 1 | This cache supplies the snooped block |
| supply_index | output | IDX_W | Line index being supplied |
| supply_dst | output | ID_W | Requester receiving the block |

## Verification
The sharpest corner is a miss that lands on a Modified line of another tag. A design that skipped the write-back would lose dirty data. One that issued the fill first would put the wrong address on the bus, and the per-cycle bus comparison catches either. Foreign write-backs and self-snoops on Modified lines are followed by loads and foreign reads of the same line. A design that reacted to them would then miss where a hit is expected, or fail to supply. The ready stall is exercised by snoops that arrive on the presented index. Grants are withheld for random stretches, so a request that drifts before its grant shows up as a changed command or address.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_M = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_IDLE = 2'd0,
    BC_GETS = 2'd1,
    BC_GETX = 2'd2,
    BC_PUTX = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NONE  = 2'd3
  } cpu_op_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WB   = 2'd1,
    PH_FILL = 2'd2,
    PH_RESP = 2'd3
  } phase_t;

  // Decision for one processor access, taken in the accept cycle.
  typedef struct packed {
    logic     need_wb;
    logic     need_fill;
    bus_cmd_t fill_cmd;
    line_st_t fill_st;
    logic     upd;
    line_st_t upd_st;
  } access_plan_t;

  function automatic access_plan_t plan_access(cpu_op_t op, line_st_t st, logic tag_eq);
    access_plan_t p;
    p.need_wb   = 1'b0;
    p.need_fill = 1'b0;
    p.fill_cmd  = BC_IDLE;
    p.fill_st   = LS_I;
    p.upd       = 1'b0;
    p.upd_st    = st;
    case (op)
      OP_LOAD: begin
        if (!(tag_eq && st != LS_I)) begin
          p.need_wb   = (st == LS_M);
          p.need_fill = 1'b1;
          p.fill_cmd  = BC_GETS;
          p.fill_st   = LS_S;
        end
      end
      OP_STORE: begin
        if (!(tag_eq && st == LS_M)) begin
          p.need_wb   = (st == LS_M);
          p.need_fill = 1'b1;
          p.fill_cmd  = BC_GETX;
          p.fill_st   = LS_M;
        end
      end
      OP_EVICT: begin
        if (tag_eq && st == LS_M) begin
          p.need_wb = 1'b1;
        end else if (tag_eq && st == LS_S) begin
          p.upd    = 1'b1;
          p.upd_st = LS_I;
        end
      end
      default: ;
    endcase
    return p;
  endfunction

  // State left behind by a foreign read that matched a valid line.
  function automatic line_st_t snoop_next(line_st_t st, bus_cmd_t cmd);
    line_st_t n;
    n = st;
    if (cmd == BC_GETX) n = LS_I;
    else if (cmd == BC_GETS && st == LS_M) n = LS_S;
    return n;
  endfunction

  function automatic logic snoop_supplies(line_st_t st, bus_cmd_t cmd);
    return (st == LS_M) && (cmd == BC_GETS || cmd == BC_GETX);
  endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             rd_a_idx,
  output line_st_t                     rd_a_st,
  output logic [TAG_W-1:0]             rd_a_tag,
  input  logic [IDX_W-1:0]             rd_b_idx,
  output line_st_t                     rd_b_st,
  output logic [TAG_W-1:0]             rd_b_tag,
  input  logic                         wa_en,
  input  logic [IDX_W-1:0]             wa_idx,
  input  line_st_t                     wa_st,
  input  logic [TAG_W-1:0]             wa_tag,
  input  logic                         wb_en,
  input  logic [IDX_W-1:0]             wb_idx,
  input  line_st_t                     wb_st,
  output line_st_t [(1<<IDX_W)-1:0]    st_vec
);

  localparam int LINES = 1 << IDX_W;

  line_st_t [LINES-1:0]             st_q;
  logic     [LINES-1:0][TAG_W-1:0]  tag_q;
  logic     [LINES-1:0]             sel_a;
  logic     [LINES-1:0]             sel_b;

  for (genvar g = 0; g < LINES; g++) begin : g_dec
    assign sel_a[g] = wa_en && (wa_idx == IDX_W'(g));
    assign sel_b[g] = wb_en && (wb_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LS_I;
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (sel_a[i]) begin
          st_q[i]  <= wa_st;
          tag_q[i] <= wa_tag;
        end else if (sel_b[i]) begin
          st_q[i] <= wb_st;
        end
      end
    end
  end

  assign rd_a_st  = st_q[rd_a_idx];
  assign rd_a_tag = tag_q[rd_a_idx];
  assign rd_b_st  = st_q[rd_b_idx];
  assign rd_b_tag = tag_q[rd_b_idx];
  assign st_vec   = st_q;

  AST_ONE_WRITER_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_en && wb_en && wa_idx == wb_idx)); // R9

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snoop_valid,
  input  logic [1:0]          snoop_cmd,
  input  logic [ADDR_W-1:0]   snoop_addr,
  input  logic [ID_W-1:0]     snoop_src,
  input  line_st_t            line_st,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  output logic [IDX_W-1:0]    snp_idx,
  output logic                wr_en,
  output line_st_t            wr_st,
  output logic                foreign,
  output logic                ev_putx,
  output logic                ev_getx_hit,
  output logic                ev_gets_hit,
  output logic                supply_valid,
  output logic [IDX_W-1:0]    supply_index,
  output logic [ID_W-1:0]     supply_dst
);

  localparam int TAG_W = ADDR_W - IDX_W;

  bus_cmd_t          cmd;
  logic [TAG_W-1:0]  snp_tag;
  logic              tag_eq;
  logic              relevant;

  assign cmd      = bus_cmd_t'(snoop_cmd);
  assign snp_idx  = snoop_addr[IDX_W-1:0];
  assign snp_tag  = snoop_addr[ADDR_W-1:IDX_W];
  assign foreign  = snoop_valid && (snoop_src != ID_W'(MY_ID));
  assign tag_eq   = (line_tag == snp_tag);
  assign relevant = foreign && tag_eq && (line_st != LS_I)
                    && (cmd == BC_GETS || cmd == BC_GETX);

  assign ev_putx     = foreign && (cmd == BC_PUTX);
  assign ev_getx_hit = relevant && (cmd == BC_GETX);
  assign ev_gets_hit = relevant && (cmd == BC_GETS);

  assign wr_st        = snoop_next(line_st, cmd);
  assign wr_en        = relevant && (wr_st != line_st);
  assign supply_valid = relevant && snoop_supplies(line_st, cmd);
  assign supply_index = snp_idx;
  assign supply_dst   = snoop_src;

  AST_SELF_SNOOP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_src == ID_W'(MY_ID)) |-> (!wr_en && !supply_valid)); // R6

  AST_SUPPLY_NEEDS_FOREIGN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    supply_valid |-> (foreign && !ev_putx)); // R3

endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [1:0]               req_op,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     snoop_block,
  output logic                     req_ready,
  output logic [IDX_W-1:0]         rd_idx,
  input  line_st_t                 line_st,
  input  logic [ADDR_W-IDX_W-1:0]  line_tag,
  output logic                     bus_req,
  output bus_cmd_t                 bus_cmd,
  output logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_gnt,
  output logic                     resp_valid,
  output logic                     resp_hit,
  output logic                     wr_en,
  output logic [IDX_W-1:0]         wr_idx,
  output line_st_t                 wr_st,
  output logic [ADDR_W-IDX_W-1:0]  wr_tag,
  output logic                     ev_accept,
  output logic                     ev_wb_done,
  output logic                     ev_fill_done
);

  localparam int TAG_W = ADDR_W - IDX_W;

  phase_t            ph_q;
  logic [ADDR_W-1:0] lat_addr;
  logic [TAG_W-1:0]  vtag_q;
  logic              fill_q;
  logic              hit_q;
  bus_cmd_t          fcmd_q;
  line_st_t          fst_q;
  access_plan_t      plan;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  lat_idx;
  logic [TAG_W-1:0]  lat_tag;
  logic              local_only;

  assign req_tag = req_addr[ADDR_W-1:IDX_W];
  assign lat_idx = lat_addr[IDX_W-1:0];
  assign lat_tag = lat_addr[ADDR_W-1:IDX_W];
  assign rd_idx  = (ph_q == PH_IDLE) ? req_addr[IDX_W-1:0] : lat_idx;

  assign plan       = plan_access(cpu_op_t'(req_op), line_st, line_tag == req_tag);
  assign local_only = !plan.need_wb && !plan.need_fill;

  assign req_ready    = (ph_q == PH_IDLE) && !snoop_block;
  assign ev_accept    = req_valid && req_ready;
  assign ev_wb_done   = (ph_q == PH_WB) && bus_gnt;
  assign ev_fill_done = (ph_q == PH_FILL) && bus_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      lat_addr <= '0;
      vtag_q   <= '0;
      fill_q   <= 1'b0;
      hit_q    <= 1'b0;
      fcmd_q   <= BC_IDLE;
      fst_q    <= LS_I;
    end else begin
      case (ph_q)
        PH_IDLE: if (ev_accept) begin
          lat_addr <= req_addr;
          vtag_q   <= line_tag;
          fill_q   <= plan.need_fill;
          fcmd_q   <= plan.fill_cmd;
          fst_q    <= plan.fill_st;
          hit_q    <= local_only;
          ph_q     <= plan.need_wb ? PH_WB : (plan.need_fill ? PH_FILL : PH_RESP);
        end
        PH_WB:   if (bus_gnt) ph_q <= fill_q ? PH_FILL : PH_RESP;
        PH_FILL: if (bus_gnt) ph_q <= PH_RESP;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = lat_idx;
    wr_st  = LS_I;
    wr_tag = lat_tag;
    if (ph_q == PH_IDLE && ev_accept && local_only && plan.upd) begin
      wr_en  = 1'b1;
      wr_idx = req_addr[IDX_W-1:0];
      wr_st  = plan.upd_st;
      wr_tag = line_tag;
    end else if (ev_wb_done) begin
      wr_en  = 1'b1;
      wr_st  = LS_I;
      wr_tag = vtag_q;
    end else if (ev_fill_done) begin
      wr_en  = 1'b1;
      wr_st  = fst_q;
      wr_tag = lat_tag;
    end
  end

  always_comb begin
    bus_req  = 1'b0;
    bus_cmd  = BC_IDLE;
    bus_addr = '0;
    if (ph_q == PH_WB) begin
      bus_req  = 1'b1;
      bus_cmd  = BC_PUTX;
      bus_addr = {vtag_q, lat_idx};
    end else if (ph_q == PH_FILL) begin
      bus_req  = 1'b1;
      bus_cmd  = fcmd_q;
      bus_addr = lat_addr;
    end
  end

  assign resp_valid = (ph_q == PH_RESP);
  assign resp_hit   = hit_q;

  AST_BUS_HELD_UNTIL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr))); // R7

  AST_FILL_FOLLOWS_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wb_done && fill_q) |=> (bus_req && bus_cmd != BC_PUTX && bus_addr == $past(lat_addr))); // R7

  AST_RESP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R8

  AST_READY_ONLY_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_req && !resp_valid)); // R9

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  input  logic [1:0]         cpu_req_op,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  output logic               cpu_req_ready,
  output logic               cpu_resp_valid,
  output logic               cpu_resp_hit,
  output logic               bus_req,
  output logic [1:0]         bus_cmd,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [ID_W-1:0]    bus_src,
  input  logic               bus_gnt,
  input  logic               snoop_valid,
  input  logic [1:0]         snoop_cmd,
  input  logic [ADDR_W-1:0]  snoop_addr,
  input  logic [ID_W-1:0]    snoop_src,
  output logic               supply_valid,
  output logic [IDX_W-1:0]   supply_index,
  output logic [ID_W-1:0]    supply_dst
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0]       p_rd_idx;
  line_st_t               p_st;
  logic [TAG_W-1:0]       p_tag;
  logic                   p_wr_en;
  logic [IDX_W-1:0]       p_wr_idx;
  line_st_t               p_wr_st;
  logic [TAG_W-1:0]       p_wr_tag;
  logic [IDX_W-1:0]       s_idx;
  line_st_t               s_st;
  logic [TAG_W-1:0]       s_tag;
  logic                   s_wr_en;
  line_st_t               s_wr_st;
  logic                   s_foreign;
  logic                   ev_putx;
  logic                   ev_getx_hit;
  logic                   ev_gets_hit;
  logic                   snoop_block;
  bus_cmd_t               bus_cmd_e;
  logic                   ev_accept;
  logic                   ev_wb_done;
  logic                   ev_fill_done;
  line_st_t [LINES-1:0]   st_vec;

  assign snoop_block = s_foreign && (s_idx == cpu_req_addr[IDX_W-1:0]);
  assign bus_cmd     = bus_cmd_e;
  assign bus_src     = ID_W'(MY_ID);

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (p_rd_idx),
    .rd_a_st  (p_st),
    .rd_a_tag (p_tag),
    .rd_b_idx (s_idx),
    .rd_b_st  (s_st),
    .rd_b_tag (s_tag),
    .wa_en    (p_wr_en),
    .wa_idx   (p_wr_idx),
    .wa_st    (p_wr_st),
    .wa_tag   (p_wr_tag),
    .wb_en    (s_wr_en),
    .wb_idx   (s_idx),
    .wb_st    (s_wr_st),
    .st_vec   (st_vec)
  );

  msi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
    .clk          (clk),
    .rst_n        (rst_n),
    .snoop_valid  (snoop_valid),
    .snoop_cmd    (snoop_cmd),
    .snoop_addr   (snoop_addr),
    .snoop_src    (snoop_src),
    .line_st      (s_st),
    .line_tag     (s_tag),
    .snp_idx      (s_idx),
    .wr_en        (s_wr_en),
    .wr_st        (s_wr_st),
    .foreign      (s_foreign),
    .ev_putx      (ev_putx),
    .ev_getx_hit  (ev_getx_hit),
    .ev_gets_hit  (ev_gets_hit),
    .supply_valid (supply_valid),
    .supply_index (supply_index),
    .supply_dst   (supply_dst)
  );

  msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (cpu_req_valid),
    .req_op       (cpu_req_op),
    .req_addr     (cpu_req_addr),
    .snoop_block  (snoop_block),
    .req_ready    (cpu_req_ready),
    .rd_idx       (p_rd_idx),
    .line_st      (p_st),
    .line_tag     (p_tag),
    .bus_req      (bus_req),
    .bus_cmd      (bus_cmd_e),
    .bus_addr     (bus_addr),
    .bus_gnt      (bus_gnt),
    .resp_valid   (cpu_resp_valid),
    .resp_hit     (cpu_resp_hit),
    .wr_en        (p_wr_en),
    .wr_idx       (p_wr_idx),
    .wr_st        (p_wr_st),
    .wr_tag       (p_wr_tag),
    .ev_accept    (ev_accept),
    .ev_wb_done   (ev_wb_done),
    .ev_fill_done (ev_fill_done)
  );

  AST_OWNER_DOWNGRADES_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_gets_hit && supply_valid) |=> (st_vec[$past(s_idx)] == LS_S)); // R3

  AST_FOREIGN_GETX_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_getx_hit |=> (st_vec[$past(s_idx)] == LS_I)); // R4

  AST_FOREIGN_PUTX_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_putx && !p_wr_en) |=> (st_vec[$past(s_idx)] == $past(st_vec[s_idx]))); // R6

  AST_FILL_LEAVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |=> (st_vec[$past(p_wr_idx)] != LS_I)); // R1

  AST_NO_ACCEPT_ON_SNOOPED_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_block |-> !ev_accept); // R9

endmodule

// File: tb/msi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_test;

  localparam int ADDR_W = 12;
  localparam int IDX_W  = 3;
  localparam int ID_W   = 2;
  localparam int LINES  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_req_valid = 1'b0;
  logic [1:0]        cpu_req_op = 2'd0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic              cpu_req_ready;
  logic              cpu_resp_valid;
  logic              cpu_resp_hit;
  logic              bus_req;
  logic [1:0]        bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic [ID_W-1:0]   bus_src;
  logic              bus_gnt = 1'b0;
  logic              snoop_valid = 1'b0;
  logic [1:0]        snoop_cmd = 2'd0;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic [ID_W-1:0]   snoop_src = '0;
  logic              supply_valid;
  logic [IDX_W-1:0]  supply_index;
  logic [ID_W-1:0]   supply_dst;

  msi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(0)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference model: line table and progress of the current request.
  int mst[LINES];
  int mtg[LINES];
  int ph = 0;
  int mop = 0;
  int maddr = 0;
  int vtag = 0;
  bit mfill = 0;
  bit mhit = 0;
  bit m_acc = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_ready();
    bit blk;
    blk = snoop_valid && (snoop_src != 0) && ((snoop_addr % LINES) == (cpu_req_addr % LINES));
    return (ph == 0) && !blk;
  endfunction

  // Model update on each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin mst[i] = 0; mtg[i] = 0; end
      ph = 0; m_acc = 0;
    end else begin
      int ri, rt, s, si, stg;
      bit eq, wb, fl, rdy;
      rdy = exp_ready();
      m_acc = 0;
      case (ph)
        0: if (cpu_req_valid && rdy) begin
          m_acc = 1;
          ri = int'(cpu_req_addr) % LINES; rt = int'(cpu_req_addr) / LINES;
          s = mst[ri]; eq = (mtg[ri] == rt);
          maddr = int'(cpu_req_addr); mop = int'(cpu_req_op); vtag = mtg[ri];
          wb = 0; fl = 0;
          if (mop == 0) begin if (!(eq && s != 0)) begin fl = 1; wb = (s == 2); end end
          else if (mop == 1) begin if (!(eq && s == 2)) begin fl = 1; wb = (s == 2); end end
          else if (mop == 2) begin
            if (eq && s == 2) wb = 1;
            else if (eq && s == 1) mst[ri] = 0;
          end
          mhit = !wb && !fl; mfill = fl;
          ph = wb ? 1 : (fl ? 2 : 3);
        end
        1: if (bus_gnt) begin mst[maddr % LINES] = 0; ph = mfill ? 2 : 3; end
        2: if (bus_gnt) begin
          mst[maddr % LINES] = (mop == 0) ? 1 : 2;
          mtg[maddr % LINES] = maddr / LINES;
          ph = 3;
        end
        default: ph = 0;
      endcase
      if (snoop_valid && snoop_src != 0 && (snoop_cmd == 1 || snoop_cmd == 2)) begin
        si = int'(snoop_addr) % LINES; stg = int'(snoop_addr) / LINES;
        if (mst[si] != 0 && mtg[si] == stg) begin
          if (snoop_cmd == 2) mst[si] = 0;
          else if (mst[si] == 2) mst[si] = 1;
        end
      end
    end
  end

  // Per-cycle comparison, away from the edge.
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      int si, stg, ecmd, eaddr;
      bit esup, ereq;
      string rq;
      chk(cpu_req_ready == exp_ready(), "R9", "cpu_req_ready", cpu_req_ready, exp_ready());
      ereq = (ph == 1 || ph == 2);
      ecmd = (ph == 1) ? 3 : ((ph == 2) ? ((mop == 0) ? 1 : 2) : 0);
      eaddr = (ph == 1) ? (vtag * LINES + maddr % LINES) : maddr;
      if (ph == 1) rq = mfill ? "R7" : "R5";
      else if (ph == 2) rq = (mop == 0) ? "R1" : "R2";
      else rq = "R7";
      chk(bus_req == ereq, rq, "bus_req", bus_req, ereq);
      chk(int'(bus_cmd) == ecmd, rq, "bus_cmd", bus_cmd, ecmd);
      if (ereq) chk(int'(bus_addr) == eaddr, rq, "bus_addr", bus_addr, eaddr);
      chk(bus_src == 0, "R7", "bus_src", bus_src, 0);
      chk(cpu_resp_valid == (ph == 3), "R8", "cpu_resp_valid", cpu_resp_valid, ph == 3);
      if (ph == 3) chk(cpu_resp_hit == mhit, "R8", "cpu_resp_hit", cpu_resp_hit, mhit);
      si = int'(snoop_addr) % LINES; stg = int'(snoop_addr) / LINES;
      esup = snoop_valid && snoop_src != 0 && (snoop_cmd == 1 || snoop_cmd == 2)
             && mst[si] == 2 && mtg[si] == stg;
      if (snoop_valid && (snoop_cmd == 3 || snoop_src == 0)) rq = "R6";
      else if (mst[si] == 2) rq = "R3";
      else rq = "R4";
      chk(supply_valid == esup, rq, "supply_valid", supply_valid, esup);
      if (esup) begin
        chk(int'(supply_index) == si, "R3", "supply_index", supply_index, si);
        chk(supply_dst == snoop_src, "R3", "supply_dst", supply_dst, snoop_src);
      end
    end
  end

  always @(negedge clk) bus_gnt <= ($urandom % 3 == 0);

  task automatic do_req(input int op, input int tag, input int idx);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_op = 2'(op); cpu_req_addr = ADDR_W'(tag * LINES + idx);
    forever begin @(negedge clk); if (m_acc) break; end
    cpu_req_valid = 1'b0;
    while (ph != 0) @(negedge clk);
  endtask

  task automatic do_snoop(input int cmd, input int tag, input int idx, input int src);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = 2'(cmd); snoop_addr = ADDR_W'(tag * LINES + idx);
    snoop_src = ID_W'(src);
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #2;
    // R10: reset state
    chk(cpu_req_ready == 1'b1, "R10", "ready in reset", cpu_req_ready, 1);
    chk(bus_req == 1'b0, "R10", "bus_req in reset", bus_req, 0);
    chk(cpu_resp_valid == 1'b0, "R10", "resp in reset", cpu_resp_valid, 0);
    chk(supply_valid == 1'b0, "R10", "supply in reset", supply_valid, 0);
    @(negedge clk); rst_n = 1'b1;

    // R10/R1: first load after reset misses, then hits
    do_req(0, 2, 1);
    do_req(0, 2, 1);
    // R2: upgrade from Shared, then silent store
    do_req(1, 2, 1);
    do_req(1, 2, 1);
    // R6: foreign PUTX and own-ID read leave the Modified line intact
    do_snoop(3, 2, 1, 1);
    do_snoop(2, 2, 1, 0);
    do_req(0, 2, 1);
    // R3: foreign read makes the owner supply and drop to Shared
    do_snoop(1, 2, 1, 3);
    do_snoop(1, 2, 1, 2);
    // R4: foreign GETX on Shared invalidates, load misses again
    do_snoop(2, 2, 1, 1);
    do_req(0, 2, 1);
    // R3: GETX on Modified supplies and invalidates
    do_req(1, 1, 4);
    do_snoop(2, 1, 4, 2);
    do_req(0, 1, 4);
    // R7: replacement of Modified by load and by store of other tags
    do_req(1, 0, 3);
    do_req(0, 5, 3);
    do_req(1, 6, 3);
    do_req(1, 7, 3);
    // R5: evictions of Modified, Shared and absent lines
    do_req(2, 7, 3);
    do_req(0, 3, 2);
    do_req(2, 3, 2);
    do_req(2, 4, 2);

    // Random traffic with held requests, stalls and withheld grants.
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if (m_acc || !cpu_req_valid) begin
        cpu_req_valid = ($urandom % 4 != 0);
        cpu_req_op    = 2'($urandom % 3);
        cpu_req_addr  = ADDR_W'(($urandom % 3) * LINES + ($urandom % 4));
      end
      if ($urandom % 3 == 0) begin
        int sidx;
        sidx = $urandom % 4;
        snoop_cmd  = 2'(1 + $urandom % 3);
        snoop_src  = ID_W'($urandom % 4);
        snoop_addr = ADDR_W'(($urandom % 3) * LINES + sidx);
        snoop_valid = !((ph == 1 || ph == 2) && sidx == (maddr % LINES));
      end else begin
        snoop_valid = 1'b0;
      end
    end
    @(negedge clk);
    cpu_req_valid = 1'b0; snoop_valid = 1'b0;
    repeat (200) begin
      if (ph == 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule